// File: doc/BRIEF.md
# Parallel Differential QPSK Encoder

This block turns a wide word of two-bit data symbols into differentially encoded QPSK drive bits for an optical IQ modulator. Every clock it can take a word of `LANES` symbols (64 by default, so 128 bits). Each symbol is first converted into a phase step, a multiple of 90 degrees. A log-depth modulo-4 prefix network then accumulates those steps across the word, starting from the last phase of the word before. Each accumulated phase is finally turned back into an in-phase/quadrature bit pair.

Symbol 0 sits in bits [1:0] of the word and is the first symbol in time. Only one two-bit value is fed back from one word to the next: the phase reached by the last lane. The long accumulation therefore runs through a pipelined combining network, not through a per-symbol recursion.

A bypass input skips the differential stage, so the raw symbols leave the block unchanged and the transmitter sends plain QPSK. A valid strobe travels next to the data.

Top module: `dqpsk_par_encoder`

## Requirements
- R1: `out_valid` equals `in_valid` as sampled three rising clock edges earlier, and every accepted word leaves the block in that same order.
- R2: A symbol pair, written as bit 2k+1 then bit 2k, becomes a phase step. 00 gives step 0, 10 gives step 1, 11 gives step 2 and 01 gives step 3, in units of 90 degrees.
- R3: Within one encoded word, the phase of lane k equals the phase carried in plus the sum of the steps of lanes 0 to k, modulo 4. Lane 0 is bits [1:0].
- R4: An accumulated phase becomes an output pair, written as bit 2k+1 then bit 2k. Phase 0 gives 00, phase 1 gives 10, phase 2 gives 11 and phase 3 gives 01.
- R5: The phase carried into an encoded word is the phase of lane `LANES-1` in the previous encoded word. Consecutive words form one continuous differential stream.
- R6: While `rst` is high at a clock edge, `out_valid` and `out_iq` go to zero and the carried phase is set to the parameter `INIT_PHASE`. The first encoded word after reset starts from that phase.
- R7: A cycle with `in_valid` low leaves the carried phase unchanged, whatever `in_sym` and `in_bypass` hold.
- R8: A word accepted with `in_bypass` high appears on `out_iq` bit for bit as it was presented, and it leaves the carried phase unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_bypass | input | 1 | Pass this word through without differential encoding |
| in_sym | input | 2*LANES | Symbol word, lane 0 in bits [1:0] |
| out_valid | output | 1 | Output word strobe, three cycles after the input |
| out_iq | output | 2*LANES | I/Q drive word, lane 0 in bits [1:0] |

## Verification
Uniform words, all 00, all 10, all 11 and all 01, each isolate one step value. They show whether the step table, the prefix sums and the output table are right, because each produces a distinct periodic phase ramp. A word with a single nonzero lane at the top shows whether the network reaches the last lane. Gaps filled with junk data, and bypass words placed between encoded words, check that only valid encoded words move the carried phase. A long seeded random stream with mixed gaps and bypass words exercises carries across many word boundaries. It also exercises every combination of prefix-sum inputs.

// File: rtl/dqe_pkg.sv
package dqe_pkg;

    typedef logic [1:0] quad_t;

    function automatic quad_t pair_to_step(input logic [1:0] pair);
        quad_t r;
        case (pair)
            2'b00:   r = 2'd0;
            2'b10:   r = 2'd1;
            2'b11:   r = 2'd2;
            default: r = 2'd3;
        endcase
        return r;
    endfunction

    function automatic logic [1:0] phase_to_pair(input quad_t ph);
        logic [1:0] r;
        case (ph)
            2'd0:    r = 2'b00;
            2'd1:    r = 2'b10;
            2'd2:    r = 2'b11;
            default: r = 2'b01;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dqe_step_map.sv
module dqe_step_map #(
    parameter int LANES = 64
) (
    input  logic [2*LANES-1:0] sym,
    output logic [2*LANES-1:0] step
);
    import dqe_pkg::*;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign step[2*k +: 2] = pair_to_step(sym[2*k +: 2]);
    end

endmodule

// File: rtl/dqe_prefix_net.sv
module dqe_prefix_net #(
    parameter int LANES = 64
) (
    input  logic [2*LANES-1:0] step,
    output logic [2*LANES-1:0] psum
);
    localparam int STAGES = $clog2(LANES);

    logic [1:0] cur [LANES];
    logic [1:0] nxt [LANES];

    // Divide-and-conquer combining: at level s, every lane whose bit s is
    // set adds the running total of the last lane of the lower half-block.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            cur[k] = step[2*k +: 2];
        end
        for (int s = 0; s < STAGES; s++) begin
            for (int k = 0; k < LANES; k++) begin
                if (((k >> s) & 1) == 1) begin
                    nxt[k] = cur[k] + cur[((k >> s) << s) - 1];
                end else begin
                    nxt[k] = cur[k];
                end
            end
            for (int k = 0; k < LANES; k++) begin
                cur[k] = nxt[k];
            end
        end
        for (int k = 0; k < LANES; k++) begin
            psum[2*k +: 2] = cur[k];
        end
    end

endmodule

// File: rtl/dqe_iq_map.sv
module dqe_iq_map #(
    parameter int LANES = 64
) (
    input  logic [2*LANES-1:0] phase,
    output logic [2*LANES-1:0] iq
);
    import dqe_pkg::*;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign iq[2*k +: 2] = phase_to_pair(phase[2*k +: 2]);
    end

endmodule

// File: rtl/dqpsk_par_encoder.sv
module dqpsk_par_encoder #(
    parameter int          LANES      = 64,
    parameter logic [1:0]  INIT_PHASE = 2'd0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_bypass,
    input  logic [2*LANES-1:0] in_sym,
    output logic               out_valid,
    output logic [2*LANES-1:0] out_iq
);
    localparam int W = 2 * LANES;

    typedef struct packed {
        logic         s1_valid;
        logic         s1_byp;
        logic [W-1:0] s1_word;
        logic         s2_valid;
        logic         s2_byp;
        logic [W-1:0] s2_word;
        logic [1:0]   carry;
        logic         o_valid;
        logic [W-1:0] o_word;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [W-1:0] step_w;
    logic [W-1:0] psum_w;
    logic [W-1:0] phase_w;
    logic [W-1:0] iq_w;
    logic [1:0]   carry_q;

    dqe_step_map #(.LANES(LANES)) u_step (
        .sym  (in_sym),
        .step (step_w)
    );

    dqe_prefix_net #(.LANES(LANES)) u_pfx (
        .step (st_q.s1_word),
        .psum (psum_w)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_base
        assign phase_w[2*k +: 2] = st_q.carry + psum_w[2*k +: 2];
    end

    dqe_iq_map #(.LANES(LANES)) u_iq (
        .phase (st_q.s2_word),
        .iq    (iq_w)
    );

    assign carry_q = st_q.carry;

    always_comb begin
        st_d = st_q;
        // stage 1: symbol pairs to phase steps
        st_d.s1_valid = in_valid;
        if (in_valid) begin
            st_d.s1_byp  = in_bypass;
            st_d.s1_word = in_bypass ? in_sym : step_w;
        end
        // stage 2: prefix accumulation on top of the carried phase
        st_d.s2_valid = st_q.s1_valid;
        if (st_q.s1_valid) begin
            st_d.s2_byp  = st_q.s1_byp;
            st_d.s2_word = st_q.s1_byp ? st_q.s1_word : phase_w;
            if (!st_q.s1_byp) begin
                st_d.carry = phase_w[W-1 -: 2];
            end
        end
        // stage 3: phases to I/Q pairs
        st_d.o_valid = st_q.s2_valid;
        if (st_q.s2_valid) begin
            st_d.o_word = st_q.s2_byp ? st_q.s2_word : iq_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.carry <= INIT_PHASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o_valid;
    assign out_iq    = st_q.o_word;

endmodule

// File: rtl/dqe_checker.sv
module dqe_checker #(
    parameter int LANES = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_bypass,
    input logic [2*LANES-1:0] in_sym,
    input logic               out_valid,
    input logic [2*LANES-1:0] out_iq,
    input logic [1:0]         phase_q
);
    import dqe_pkg::*;

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    function automatic logic [1:0] word_total(input logic [2*LANES-1:0] w);
        logic [1:0] t;
        t = 2'd0;
        for (int k = 0; k < LANES; k++) begin
            t = t + pair_to_step(w[2*k +: 2]);
        end
        return t;
    endfunction

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R1

    AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && $past(in_valid && in_bypass, 3)) |->
        (out_iq == $past(in_sym, 3))); // R8

    AST_CARRY_STEP: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && $past(in_valid && !in_bypass, 2)) |->
        (phase_q == $past(phase_q) + $past(word_total(in_sym), 2))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !$past(in_valid, 2)) |-> $stable(phase_q)); // R7

    AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && $past(in_valid && in_bypass, 2)) |-> $stable(phase_q)); // R8

endmodule

bind dqpsk_par_encoder dqe_checker #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bypass (in_bypass),
    .in_sym    (in_sym),
    .out_valid (out_valid),
    .out_iq    (out_iq),
    .phase_q   (carry_q)
);

// File: tb/dqpsk_par_encoder_test.sv
module dqpsk_par_encoder_test;

    localparam int L = 64;
    localparam int W = 2 * L;
    localparam logic [1:0] START_PH = 2'd2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_bypass = 1'b0;
    logic [W-1:0] in_sym = '0;
    logic         out_valid;
    logic [W-1:0] out_iq;

    int checks = 0;
    int errors = 0;

    logic [1:0]   model_ph;
    logic         hv [3];
    logic [W-1:0] hd [3];
    string        ht [3];

    always #10 clk = ~clk;

    dqpsk_par_encoder #(.LANES(L), .INIT_PHASE(START_PH)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bypass (in_bypass),
        .in_sym    (in_sym),
        .out_valid (out_valid),
        .out_iq    (out_iq)
    );

    function automatic logic [1:0] ref_step(input logic [1:0] p);
        if (p == 2'b00) return 2'd0;
        if (p == 2'b10) return 2'd1;
        if (p == 2'b11) return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [1:0] ref_pair(input logic [1:0] ph);
        if (ph == 2'd0) return 2'b00;
        if (ph == 2'd1) return 2'b10;
        if (ph == 2'd2) return 2'b11;
        return 2'b01;
    endfunction

    task automatic step(input logic v, input logic byp, input logic [W-1:0] w, input string tag);
        logic [W-1:0] e;
        @(negedge clk);
        checks++;
        if (out_valid !== hv[2]) begin
            errors++;
            $display("FAIL R1: out_valid got %b expected %b", out_valid, hv[2]);
        end
        if (hv[2]) begin
            checks++;
            if (out_iq !== hd[2]) begin
                errors++;
                $display("FAIL %s: out_iq got %h expected %h", ht[2], out_iq, hd[2]);
            end
        end
        hv[2] = hv[1]; hd[2] = hd[1]; ht[2] = ht[1];
        hv[1] = hv[0]; hd[1] = hd[0]; ht[1] = ht[0];
        e = '0;
        if (v) begin
            if (byp) begin
                e = w;
            end else begin
                for (int k = 0; k < L; k++) begin
                    model_ph = model_ph + ref_step(w[2*k +: 2]);
                    e[2*k +: 2] = ref_pair(model_ph);
                end
            end
        end
        hv[0] = v; hd[0] = e; ht[0] = tag;
        in_valid  = v;
        in_bypass = byp;
        in_sym    = w;
    endtask

    function automatic logic [W-1:0] rnd_word();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_ph = START_PH;
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0; hd[i] = '0; ht[i] = "R1";
        end
        // R6: outputs cleared while reset is held
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_iq !== '0) begin
            errors++;
            $display("FAIL R6: reset outputs got %b/%h expected 0/0", out_valid, out_iq);
        end
        rst = 1'b0;
        // R6: all-zero word holds the start phase, every pair 11
        step(1'b1, 1'b0, '0, "R6");
        // R2/R3/R4: uniform words give distinct phase ramps
        step(1'b1, 1'b0, {L{2'b10}}, "R3");
        step(1'b1, 1'b0, {L{2'b11}}, "R2");
        step(1'b1, 1'b0, {L{2'b01}}, "R4");
        step(1'b1, 1'b0, {2'b11, {(L-1){2'b00}}}, "R3");
        step(1'b1, 1'b0, {{(L-1){2'b00}}, 2'b10}, "R3");
        // R7: idle cycles with junk data leave the phase alone
        for (int i = 0; i < 3; i++) step(1'b0, i[0], rnd_word(), "R7");
        step(1'b1, 1'b0, '0, "R7");
        // R8: bypass words pass raw and do not move the phase
        step(1'b1, 1'b1, rnd_word(), "R8");
        step(1'b1, 1'b1, {L{2'b10}}, "R8");
        step(1'b1, 1'b0, '0, "R8");
        // R5: long random stream with gaps and bypass words
        for (int i = 0; i < 300; i++) begin
            automatic int r = $urandom % 8;
            step(r != 0, r == 1, rnd_word(), "R5");
        end
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, '0, "R1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule